// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits in the always-on part of a small microcontroller and controls its two low-power modes through one 8-bit control register. Software sets a light-sleep bit to stop the processor clock while timers, serial port and interrupt logic keep running. It sets a deep-sleep bit to stop the oscillator and gate every clock. The register also holds a double-rate flag for the serial baud generator and two spare flags for software.

Light sleep ends when the interrupt logic reports an enabled pending interrupt, or when the reset pin is held. Deep sleep ends only through the reset pin or an enabled external interrupt pin. Pulling such a pin low restarts the oscillator. After a stabilisation count, the first held pin that returns high finishes the wake-up. The clock `clk` is the block's always-available timebase. `osc_en`, `cpu_clk_en` and `per_clk_en` are the enables it hands to the oscillator and the clock gates.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After power-on reset the register reads 0x00, `dbl_baud` is 0, and `osc_en`, `cpu_clk_en` and `per_clk_en` are all 1.
- R2: Bit 7 is the double-baud flag and drives `dbl_baud`. Bits 3 and 2 are software flags that read back as written. Bits 6 to 4 always read 0, whatever is written.
- R3: Writing a 1 to bit 0 (light sleep) with bit 1 clear drops `cpu_clk_en` after that clock edge. `per_clk_en` and `osc_en` stay 1.
- R4: In light sleep, `irq_pend` high at a clock edge clears bit 0 and raises `cpu_clk_en` after that edge. Bits 7, 3 and 2 are unchanged.
- R5: Writing a 1 to bit 1 (deep sleep) drops `osc_en`, `cpu_clk_en` and `per_clk_en` after that edge. `irq_pend` alone does not end deep sleep.
- R6: In deep sleep, a pin of `ext_int_n` that is low and enabled in `ext_int_en` raises `osc_en` after the next edge, with both clock enables still 0. The clocks return on the edge after which STABLE_CYCLES edges have passed since the restart began, provided a held pin has been released by then. Otherwise they return on the first edge at which a held pin is seen high. The exit clears bits 1 and 0 and keeps bits 7, 3 and 2.
- R7: A low `ext_int_n` pin whose `ext_int_en` bit is 0 leaves deep sleep untouched.
- R8: With bits 1 and 0 both written to 1, the block behaves as in deep sleep. The pin wake-up clears both bits and ends in full run with `cpu_clk_en` at 1, not in light sleep.
- R9: `rst_req` high for RST_CYCLES consecutive edges clears the register to 0x00 and returns the block to full run. RST_CYCLES-1 edges has no effect.
- R10: A completed reset during deep sleep clears the register and raises `osc_en` at once. The clock enables stay 0 until STABLE_CYCLES edges have been counted.
- R11: Register writes are ignored while `cpu_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-available timebase |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Reset pin level, qualified by a hold count |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_int_n | input | N_EXT | External interrupt pins, active low |
| ext_int_en | input | N_EXT | Enables for the external interrupt pins |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| per_clk_en | output | 1 | Timer, serial and interrupt clock gate enable |
| osc_en | output | 1 | Oscillator run enable |
| dbl_baud | output | 1 | Double baud-rate select |

## Verification
If the mode state is wrong, the three enables show it on the very next edge after a write, an interrupt or a pin change. A processor clock that comes back too early or too late during wake-up shows up as a one-cycle shift against the stabilisation count. A stray register update shows up when the register is read back after the exit: flags that should have survived read wrong, or sleep bits that should have cleared are still set. A hold counter off by one shows at the boundary between RST_CYCLES-1 and RST_CYCLES edges of reset.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int RST_CYCLES    = 24,
  parameter int STABLE_CYCLES = 64,
  parameter int N_EXT         = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_req,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             irq_pend,
  input  logic [N_EXT-1:0] ext_int_n,
  input  logic [N_EXT-1:0] ext_int_en,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             dbl_baud
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam int SW = $clog2(STABLE_CYCLES + 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PDN, S_WAKE, S_RSTAB} st_t;

  st_t              state;
  logic             smod, gf1, gf0, pd, idl;
  logic [RW-1:0]    rst_cnt;
  logic [SW-1:0]    stab_cnt;
  logic [N_EXT-1:0] held;
  logic             rel_seen;

  wire             in_rst   = rst_req && (rst_cnt == RW'(RST_CYCLES - 1));
  wire             stable   = (stab_cnt == SW'(STABLE_CYCLES - 1));
  wire [N_EXT-1:0] pin_low  = ext_int_en & ~ext_int_n;
  wire             rel_now  = |(held & ext_int_n);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                          rst_cnt <= '0;
    else if (!rst_req)                    rst_cnt <= '0;
    else if (rst_cnt != RW'(RST_CYCLES - 1)) rst_cnt <= rst_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= S_RUN;
      {smod, gf1, gf0, pd, idl} <= '0;
      held     <= '0;
      rel_seen <= 1'b0;
      stab_cnt <= '0;
    end else if (in_rst) begin
      {smod, gf1, gf0, pd, idl} <= '0;
      held     <= '0;
      rel_seen <= 1'b0;
      if (state == S_PDN || state == S_WAKE) begin
        state    <= S_RSTAB;
        stab_cnt <= '0;
      end else if (state == S_RSTAB) begin
        if (!stable) stab_cnt <= stab_cnt + 1'b1;
        else         state    <= S_RUN;
      end else begin
        state <= S_RUN;
      end
    end else begin
      case (state)
        S_RUN: if (reg_we) begin
          smod <= reg_wdata[7];
          gf1  <= reg_wdata[3];
          gf0  <= reg_wdata[2];
          pd   <= reg_wdata[1];
          idl  <= reg_wdata[0];
          if (reg_wdata[1])      state <= S_PDN;
          else if (reg_wdata[0]) state <= S_IDLE;
        end
        S_IDLE: if (irq_pend) begin
          idl   <= 1'b0;
          state <= S_RUN;
        end
        S_PDN: if (|pin_low) begin
          held     <= pin_low;
          rel_seen <= 1'b0;
          stab_cnt <= '0;
          state    <= S_WAKE;
        end
        S_WAKE: begin
          held <= held | pin_low;
          if (rel_now) rel_seen <= 1'b1;
          if (!stable) stab_cnt <= stab_cnt + 1'b1;
          else if (rel_seen || rel_now) begin
            pd    <= 1'b0;
            idl   <= 1'b0;
            state <= S_RUN;
          end
        end
        S_RSTAB: begin
          if (!stable) stab_cnt <= stab_cnt + 1'b1;
          else         state    <= S_RUN;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign reg_rdata  = {smod, 3'b000, gf1, gf0, pd, idl};
  assign dbl_baud   = smod;
  assign cpu_clk_en = (state == S_RUN);
  assign per_clk_en = (state == S_RUN) || (state == S_IDLE);
  assign osc_en     = (state != S_PDN);
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int N_EXT = 2
) (
  input logic             clk,
  input logic             arst_n,
  input logic             rst_req,
  input logic [7:0]       reg_rdata,
  input logic             irq_pend,
  input logic [N_EXT-1:0] ext_int_n,
  input logic [N_EXT-1:0] ext_int_en,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             osc_en
);
  wire wake_pin = |(ext_int_en & ~ext_int_n);

  p_cpu_needs_per_r3: assert property (@(posedge clk) disable iff (!arst_n)
    cpu_clk_en |-> per_clk_en);

  p_per_needs_osc_r5: assert property (@(posedge clk) disable iff (!arst_n)
    per_clk_en |-> osc_en);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!arst_n)
    reg_rdata[6:4] == 3'b000);

  p_idle_exit_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (!cpu_clk_en && per_clk_en && irq_pend) |=> cpu_clk_en);

  p_pd_holds_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (!osc_en && !rst_req && !wake_pin) |=> !osc_en);

  p_pin_restarts_osc_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (!osc_en && wake_pin) |=> (osc_en && !cpu_clk_en));

  p_gated_no_write_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (!cpu_clk_en && !rst_req) |=> $stable({reg_rdata[7], reg_rdata[3:2]}));
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.N_EXT(N_EXT)) u_chk (
  .clk(clk), .arst_n(arst_n), .rst_req(rst_req), .reg_rdata(reg_rdata),
  .irq_pend(irq_pend), .ext_int_n(ext_int_n), .ext_int_en(ext_int_en),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en)
);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 24;
  localparam int STAB = 8;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       rst_req = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_pend = 1'b0;
  logic [1:0] ext_int_n = 2'b11;
  logic [1:0] ext_int_en = 2'b00;
  logic       cpu_clk_en, per_clk_en, osc_en, dbl_baud;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.RST_CYCLES(RSTC), .STABLE_CYCLES(STAB), .N_EXT(2)) u_dut (
    .clk(clk), .arst_n(arst_n), .rst_req(rst_req),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pend(irq_pend), .ext_int_n(ext_int_n), .ext_int_en(ext_int_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .dbl_baud(dbl_baud)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  function automatic int clks();
    return {osc_en, per_clk_en, cpu_clk_en};
  endfunction

  task automatic t_reset_r1;
    chk_eq("R1 reg", reg_rdata, 8'h00);
    chk_eq("R1 dbl_baud", dbl_baud, 0);
    chk_eq("R1 osc/per/cpu", clks(), 3'b111);
  endtask

  task automatic t_fields_r2;
    wr(8'h8C);
    chk_eq("R2 flags readback", reg_rdata, 8'h8C);
    chk_eq("R2 dbl_baud set", dbl_baud, 1);
    wr(8'h70);
    chk_eq("R2 reserved read zero", reg_rdata, 8'h00);
    chk_eq("R2 dbl_baud clear", dbl_baud, 0);
    wr(8'h88);
    chk_eq("R2 smod+gf1", reg_rdata, 8'h88);
  endtask

  task automatic t_idle_r3_r4;
    wr(8'h89);
    chk_eq("R3 idle clocks", clks(), 3'b110);
    chk_eq("R3 idle reg", reg_rdata, 8'h89);
    tick(5);
    chk_eq("R3 idle persists", clks(), 3'b110);
    irq_pend = 1'b1;
    tick(1);
    irq_pend = 1'b0;
    chk_eq("R4 idle exit clocks", clks(), 3'b111);
    chk_eq("R4 idle exit reg", reg_rdata, 8'h88);
  endtask

  task automatic t_gated_write_r11;
    wr(8'h89);
    reg_we = 1'b1;
    reg_wdata = 8'h04;
    tick(2);
    reg_we = 1'b0;
    chk_eq("R11 write ignored in idle", reg_rdata, 8'h89);
    irq_pend = 1'b1;
    tick(1);
    irq_pend = 1'b0;
    chk_eq("R11 reg after exit", reg_rdata, 8'h88);
  endtask

  task automatic t_pd_held_r5_r6_r7;
    ext_int_en = 2'b01;
    wr(8'h8A);
    chk_eq("R5 pd clocks off", clks(), 3'b000);
    irq_pend = 1'b1;
    tick(3);
    irq_pend = 1'b0;
    chk_eq("R5 irq ignored in pd", clks(), 3'b000);
    ext_int_n = 2'b01;
    tick(3);
    chk_eq("R7 disabled pin ignored", clks(), 3'b000);
    ext_int_n = 2'b11;
    tick(1);
    ext_int_n = 2'b10;
    tick(1);
    chk_eq("R6 osc restart", clks(), 3'b100);
    tick(STAB + 3);
    chk_eq("R6 wait for release", clks(), 3'b100);
    ext_int_n = 2'b11;
    tick(1);
    chk_eq("R6 exit on release", clks(), 3'b111);
    chk_eq("R6 reg after exit", reg_rdata, 8'h88);
  endtask

  task automatic t_pd_early_r6;
    wr(8'h8A);
    ext_int_n = 2'b10;
    tick(1);
    ext_int_n = 2'b11;
    chk_eq("R6 early osc on", clks(), 3'b100);
    tick(STAB - 1);
    chk_eq("R6 still stabilising", clks(), 3'b100);
    tick(1);
    chk_eq("R6 exit after count", clks(), 3'b111);
    chk_eq("R6 early reg", reg_rdata, 8'h88);
  endtask

  task automatic t_both_r8;
    ext_int_en = 2'b11;
    wr(8'h8B);
    chk_eq("R8 both bits as pd", clks(), 3'b000);
    ext_int_n = 2'b01;
    tick(STAB + 1);
    ext_int_n = 2'b11;
    tick(1);
    chk_eq("R8 run after wake", clks(), 3'b111);
    chk_eq("R8 both bits cleared", reg_rdata, 8'h88);
    tick(3);
    chk_eq("R8 idle not entered", clks(), 3'b111);
  endtask

  task automatic t_rst_r9;
    wr(8'h89);
    rst_req = 1'b1;
    tick(RSTC - 1);
    rst_req = 1'b0;
    tick(1);
    chk_eq("R9 short reset no effect", reg_rdata, 8'h89);
    chk_eq("R9 short reset still idle", clks(), 3'b110);
    rst_req = 1'b1;
    tick(RSTC);
    chk_eq("R9 reset clears reg", reg_rdata, 8'h00);
    chk_eq("R9 reset run", clks(), 3'b111);
    rst_req = 1'b0;
    tick(1);
  endtask

  task automatic t_rst_pd_r10;
    wr(8'h8E);
    chk_eq("R10 pd entered", clks(), 3'b000);
    rst_req = 1'b1;
    tick(RSTC);
    rst_req = 1'b0;
    chk_eq("R10 reg cleared", reg_rdata, 8'h00);
    chk_eq("R10 osc on clocks gated", clks(), 3'b100);
    tick(STAB - 1);
    chk_eq("R10 still stabilising", clks(), 3'b100);
    tick(1);
    chk_eq("R10 run after count", clks(), 3'b111);
  endtask

  initial begin
    tick(3);
    arst_n = 1'b1;
    tick(1);
    t_reset_r1();
    t_fields_r2();
    t_idle_r3_r4();
    t_gated_write_r11();
    t_pd_held_r5_r6_r7();
    t_pd_early_r6();
    t_both_r8();
    t_rst_r9();
    t_rst_pd_r10();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule